// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command nodes stored in a 2 MB main memory. It hands every payload word, in order, to a downstream command consumer. A node starts with one header word. The top byte of the header is the number of payload words, and the low 24 bits point to the next node. The payload words sit directly after the header. A walk starts from a 24-bit pointer and continues from node to node. It stops at the first pointer whose bit 23 is set.

For every node the block adds an estimated cost of five plus the payload count to a running total. When the walk ends, it raises a one-cycle done pulse and presents the pointer it stopped on and the total cost.

The block also guards against chains that loop back on themselves. Once a set number of nodes has been visited, it sets bit 23 in each header it passes. A loop that comes back to one of those headers therefore stops. Before signalling done, it walks again from the first marked header and clears every mark it added, so memory is left as it was.

Top module: `chain_walker`

## Requirements
- R1: A pulse on `start` while idle loads the 24-bit `start_addr`. The walk visits nodes while bit 23 of the current pointer is 0. A start pointer that already has bit 23 set ends the walk at once, with no payload and a cost of 0.
- R2: The header word carries the payload count in bits 31:24 and the next pointer in bits 23:0. The payload words are read from the byte addresses header+4, header+8, and so on. Only the low 21 bits of any pointer drive `mem_addr`. The words leave on `out_data` in chain order, with nothing dropped and nothing repeated.
- R3: A node whose count is 0 sends no word to the consumer and only moves the walk on to its next pointer.
- R4: At done, `done_cost` equals the sum over all visited nodes of (5 + count).
- R5: `done` is high for exactly one cycle per walk. While it is high, `done_addr` holds the 24-bit pointer that ended the walk, and bit 23 of that pointer is set.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays unchanged, and no memory read is issued.
- R7: A header is marked by writing it back with bit 23 set. This happens for each visited node whose 0-based visit index is at least `TAG_AFTER` and whose header has bit 23 clear. A node reached again through a marked header has its payload sent once more, and then the walk stops.
- R8: By the cycle `done` rises, every header marked under R7 has had bit 23 restored to 0. Memory then matches its contents before the walk.
- R9: `start` has no effect while `busy` is high.
- R10: After reset, `busy`, `done`, `out_valid`, `mem_rd` and `mem_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 24 | First node pointer |
| busy | output | 1 | A walk or mark cleanup is in progress |
| mem_rd | output | 1 | Memory read request; data returns on `mem_rdata` next cycle |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W (21) | Byte address of a 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, held until the next read |
| out_valid | output | 1 | Payload word available |
| out_ready | input | 1 | Consumer accepts the payload word |
| out_data | output | 32 | Payload word |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_addr | output | 24 | Pointer that ended the walk |
| done_cost | output | COST_W (32) | Accumulated node cost |

## Verification
The assertions assume three things about the memory port. Read data arrives one cycle after a read request. It then stays unchanged until the next request. No node's payload overlaps a header. The stall-stability property also relies on the consumer holding `out_ready` for a whole cycle.

The bench memory model keeps read data registered. The bench places nodes on separate 64-byte slots so payloads never cover headers. It drives `out_ready` only at falling edges. It mixes random chains and random back-pressure with directed zero-count nodes, self-loops, cycles with a tail, long terminated chains past the marking threshold, and a `start` pulse during a busy walk.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

    localparam int PTR_W         = 24;
    localparam int END_BIT       = 23;
    localparam int LEN_W         = 8;
    localparam int WORD_W        = 32;
    localparam int WORD_BYTES    = 4;
    localparam int NODE_OVERHEAD = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR,
        ST_TAG,
        ST_PAY_START,
        ST_PAY,
        ST_CLR_RD,
        ST_CLR_WR,
        ST_DONE
    } walk_state_e;

    // Header word: count in the top byte, next pointer below.
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] next;
    } node_hdr_t;

    function automatic logic [LEN_W:0] node_cost(input logic [LEN_W-1:0] len);
        return (LEN_W+1)'(NODE_OVERHEAD) + {1'b0, len};
    endfunction

    function automatic node_hdr_t with_mark(input node_hdr_t h, input logic mark);
        node_hdr_t r;
        r = h;
        r.next[END_BIT] = mark;
        return r;
    endfunction

endpackage

// File: rtl/cw_cost_acc.sv
module cw_cost_acc
    import chain_walker_pkg::*;
#(
    parameter int COST_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add_en,
    input  logic [LEN_W-1:0]  add_len,
    output logic [COST_W-1:0] total
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            total <= '0;
        end else if (add_en) begin
            total <= total + COST_W'(node_cost(add_len));
        end
    end

endmodule

// File: rtl/cw_guard_ctr.sv
module cw_guard_ctr #(
    parameter int TAG_AFTER = 8192,
    parameter int TCNT_W    = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              node_step,
    input  logic              tag_step,
    input  logic              untag_step,
    output logic              guard_on,
    output logic [TCNT_W-1:0] tag_cnt
);

    localparam int NCNT_W = $clog2(TAG_AFTER + 1);

    logic [NCNT_W-1:0] node_cnt;

    // Saturates at the threshold: only "at or past it" matters.
    assign guard_on = (node_cnt == NCNT_W'(TAG_AFTER));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            node_cnt <= '0;
        end else if (node_step && !guard_on) begin
            node_cnt <= node_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tag_cnt <= '0;
        end else if (tag_step) begin
            tag_cnt <= tag_cnt + 1'b1;
        end else if (untag_step) begin
            tag_cnt <= tag_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/chain_walker.sv
module chain_walker
    import chain_walker_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int COST_W    = 32,
    parameter int TAG_AFTER = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [23:0]       start_addr,
    output logic              busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              done,
    output logic [23:0]       done_addr,
    output logic [COST_W-1:0] done_cost
);

    // Enough to count every word-aligned node the memory can hold.
    localparam int TCNT_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    walk_state_e       state;
    logic [PTR_W-1:0]  cur_ptr;
    node_hdr_t         hdr_q;
    node_hdr_t         rd_hdr;
    logic [LEN_W-1:0]  remain;
    logic [ADDR_W-1:0] pay_addr;
    logic [ADDR_W-1:0] pay_next;
    logic [ADDR_W-1:0] first_tag;
    logic [ADDR_W-1:0] clr_addr;

    logic              acc_clear;
    logic              guard_on;
    logic [TCNT_W-1:0] tag_cnt;
    logic              in_hdr;
    logic              in_tag;
    logic              in_clr_wr;

    assign rd_hdr    = node_hdr_t'(mem_rdata);
    assign pay_next  = pay_addr + STEP;
    assign acc_clear = (state == ST_IDLE) && start;
    assign in_hdr    = (state == ST_HDR);
    assign in_tag    = (state == ST_TAG);
    assign in_clr_wr = (state == ST_CLR_WR);

    cw_cost_acc #(.COST_W(COST_W)) cost_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (acc_clear),
        .add_en  (in_hdr),
        .add_len (rd_hdr.len),
        .total   (done_cost)
    );

    cw_guard_ctr #(.TAG_AFTER(TAG_AFTER), .TCNT_W(TCNT_W)) guard_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (acc_clear),
        .node_step  (in_hdr),
        .tag_step   (in_tag),
        .untag_step (in_clr_wr),
        .guard_on   (guard_on),
        .tag_cnt    (tag_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_ptr   <= '0;
            hdr_q     <= '0;
            remain    <= '0;
            pay_addr  <= '0;
            first_tag <= '0;
            clr_addr  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cur_ptr <= start_addr;
                    state   <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!cur_ptr[END_BIT]) begin
                        state <= ST_HDR;
                    end else if (tag_cnt != '0) begin
                        clr_addr <= first_tag;
                        state    <= ST_CLR_RD;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_HDR: begin
                    hdr_q    <= rd_hdr;
                    remain   <= rd_hdr.len;
                    pay_addr <= cur_ptr[ADDR_W-1:0] + STEP;
                    state    <= (guard_on && !rd_hdr.next[END_BIT]) ? ST_TAG : ST_PAY_START;
                end
                ST_TAG: begin
                    if (tag_cnt == '0) begin
                        first_tag <= cur_ptr[ADDR_W-1:0];
                    end
                    state <= ST_PAY_START;
                end
                ST_PAY_START: begin
                    if (remain == '0) begin
                        cur_ptr <= hdr_q.next;
                        state   <= ST_CHECK;
                    end else begin
                        state <= ST_PAY;
                    end
                end
                ST_PAY: if (out_ready) begin
                    remain   <= remain - 1'b1;
                    pay_addr <= pay_next;
                    if (remain == LEN_W'(1)) begin
                        cur_ptr <= hdr_q.next;
                        state   <= ST_CHECK;
                    end
                end
                ST_CLR_RD: state <= ST_CLR_WR;
                ST_CLR_WR: begin
                    clr_addr <= rd_hdr.next[ADDR_W-1:0];
                    state    <= (tag_cnt == TCNT_W'(1)) ? ST_DONE : ST_CLR_RD;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = cur_ptr[ADDR_W-1:0];
        mem_wdata = with_mark(hdr_q, 1'b1);
        unique case (state)
            ST_CHECK:     mem_rd = !cur_ptr[END_BIT];
            ST_TAG:       mem_wr = 1'b1;
            ST_PAY_START: begin
                mem_rd   = (remain != '0);
                mem_addr = pay_addr;
            end
            ST_PAY: begin
                // Next word is fetched only on an accepted handshake.
                mem_rd   = out_ready && (remain != LEN_W'(1));
                mem_addr = pay_next;
            end
            ST_CLR_RD: begin
                mem_rd   = 1'b1;
                mem_addr = clr_addr;
            end
            ST_CLR_WR: begin
                mem_wr    = 1'b1;
                mem_addr  = clr_addr;
                mem_wdata = with_mark(rd_hdr, 1'b0);
            end
            default: ;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign out_valid = (state == ST_PAY);
    assign out_data  = mem_rdata;
    assign done      = (state == ST_DONE);
    assign done_addr = cur_ptr;

endmodule

// File: rtl/chain_walker_checks.sv
module chain_walker_checks #(
    parameter int ADDR_W = 21
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [23:0] done_addr,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        mem_rd,
    input logic        mem_wr
);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_stall_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !mem_rd);

    p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_term_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> done_addr[23]);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr && !out_valid && !done));

    p_start_taken_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

bind chain_walker chain_walker_checks #(.ADDR_W(ADDR_W)) checks_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .done_addr (done_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/chain_walker_tb_top.sv
`timescale 1ns/1ps
module chain_walker_tb_top;

    localparam int ADDR_W = 21;
    localparam int COST_W = 32;
    localparam int TAG_N  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [23:0]       start_addr = '0;
    logic              busy, mem_rd, mem_wr, out_valid, done;
    logic              out_ready = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, out_data;
    logic [31:0]       mem_rdata = '0;
    logic [23:0]       done_addr;
    logic [COST_W-1:0] done_cost;

    always #2 clk = ~clk;

    chain_walker #(.ADDR_W(ADDR_W), .COST_W(COST_W), .TAG_AFTER(TAG_N)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .busy(busy),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done), .done_addr(done_addr), .done_cost(done_cost)
    );

    // Sparse word memory, indexed by byte address / 4.
    logic [31:0] mem  [int unsigned];
    logic [31:0] orig [int unsigned];

    function automatic logic [31:0] peek(input int unsigned w);
        return mem.exists(w) ? mem[w] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_wr) mem[int'(mem_addr[ADDR_W-1:2])] = mem_wdata;
        if (mem_rd) mem_rdata <= peek(int'(mem_addr[ADDR_W-1:2]));
    end

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          rnd_ready = 1'b0;
    logic [31:0] got_q [$];
    logic [31:0] exp_q [$];
    logic [31:0] exp_cost;
    logic [23:0] exp_addr;
    int          done_cnt;
    logic [23:0] got_addr;
    logic [31:0] got_cost;
    int          stall_bad;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Drive ready at the falling edge, then sample what the next rising edge sees.
    always begin
        @(negedge clk);
        out_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
        #1;
        if (!rst) begin
            if (prev_stall && !(out_valid && out_data == prev_data)) stall_bad++;
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (out_valid && !out_ready) begin
                if (mem_rd) stall_bad++;
                prev_stall = 1'b1;
                prev_data  = out_data;
            end else begin
                prev_stall = 1'b0;
            end
            if (done) begin
                done_cnt++;
                got_addr = done_addr;
                got_cost = done_cost;
            end
        end
    end

    // Reference walk on a private copy of memory, including header marking.
    task automatic model(input logic [23:0] sa);
        logic [31:0] wm [int unsigned];
        logic [23:0] p;
        int          n;
        wm = mem;
        exp_q.delete();
        exp_cost = 0;
        p = sa;
        n = 0;
        while (!p[23] && n < 100000) begin
            int unsigned a;
            logic [31:0] h;
            a = int'(p[20:2]);
            h = wm.exists(a) ? wm[a] : 32'h0;
            exp_cost += 32'd5 + 32'(h[31:24]);
            if (n >= TAG_N && !h[23]) wm[a] = h | 32'h0080_0000;
            for (int i = 1; i <= int'(h[31:24]); i++) begin
                int unsigned b;
                b = (a + i) % (1 << 19);
                exp_q.push_back(wm.exists(b) ? wm[b] : 32'h0);
            end
            n++;
            p = h[23:0];
        end
        exp_addr = p;
    endtask

    function automatic logic [23:0] ptr(input logic [20:0] a);
        return {1'b0, 2'($urandom), a};
    endfunction

    task automatic put_node(input logic [20:0] a, input int len, input logic [23:0] nxt);
        mem[int'(a[20:2])] = {8'(len), nxt};
        for (int i = 1; i <= len; i++) mem[int'(a[20:2]) + i] = $urandom;
    endtask

    task automatic run_walk(input logic [23:0] sa, input string name, input bit poke);
        int  waited;
        bit  mem_ok;
        orig = mem;
        model(sa);
        got_q.delete();
        done_cnt  = 0;
        stall_bad = 0;
        @(negedge clk);
        start = 1'b1;
        start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b1, "R9", {name, " busy before poke"}, busy, 1);
            start = 1'b1;
            start_addr = 24'h000040;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_cnt != 0, "R5", {name, " walk finished"}, done_cnt, 1);
        if (done_cnt == 0) begin
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
        mem_ok = (mem.num() == orig.num());
        foreach (orig[k]) if (!mem.exists(k) || mem[k] != orig[k]) mem_ok = 1'b0;
        chk(mem_ok, "R8", {name, " memory restored"}, mem.num(), orig.num());
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R5", {name, " single done pulse"}, done_cnt, 1);
        chk(got_addr == exp_addr, "R5", {name, " done_addr"}, got_addr, exp_addr);
        chk(got_cost == exp_cost, "R4", {name, " cost"}, got_cost, exp_cost);
        chk(got_q.size() == exp_q.size(), "R2", {name, " payload count"},
            got_q.size(), exp_q.size());
        begin
            bit same;
            same = 1'b1;
            foreach (exp_q[i]) if (i < got_q.size() && got_q[i] != exp_q[i]) same = 1'b0;
            chk(same, "R2", {name, " payload order"}, same, 1);
        end
        chk(stall_bad == 0, "R6", {name, " stall hold"}, stall_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!busy && !done && !out_valid && !mem_rd && !mem_wr, "R10", "reset state",
            {busy, done, out_valid, mem_rd, mem_wr}, 0);

        // R1: terminator as the start pointer.
        mem.delete();
        run_walk(24'h9A_BC00, "r1_term_start", 1'b0);
        chk(got_q.size() == 0, "R1", "no payload on terminator start", got_q.size(), 0);

        // R2/R3: directed chain with zero-count nodes and high pointer bits.
        mem.delete();
        put_node(21'h000100, 3, 24'h600200);
        put_node(21'h000200, 0, 24'h000300);
        put_node(21'h000300, 2, 24'h200400);
        put_node(21'h000400, 0, 24'h85_5555);
        run_walk(24'h400100, "r3_zero_nodes", 1'b0);
        chk(got_q.size() == 5, "R3", "zero nodes add nothing", got_q.size(), 5);

        // R2/R4/R6: random chains, random back-pressure, past and below the mark threshold.
        rnd_ready = 1'b1;
        for (int t = 0; t < 10; t++) begin
            logic [20:0] base;
            int nn;
            mem.delete();
            base = 21'(($urandom % 1024) * 1024);
            nn = 1 + ($urandom % 11);
            for (int k = 0; k < nn; k++) begin
                logic [23:0] nx;
                nx = (k == nn - 1) ? (24'h80_0000 | 24'($urandom)) : ptr(base + 21'((k + 1) * 64));
                put_node(base + 21'(k * 64), $urandom % 8, nx);
            end
            run_walk({3'b000, base}, $sformatf("r2_rand%0d", t), t == 3);
        end

        // R7/R8: self-loop, pure cycle, cycle with a tail, and the boundary at the wrap.
        mem.delete();
        put_node(21'h010000, 2, 24'h010000);
        run_walk(24'h010000, "r7_self_loop", 1'b0);
        chk(got_addr == 24'h810000, "R7", "self loop stop ptr", got_addr, 24'h810000);

        mem.delete();
        put_node(21'h020000, 1, 24'h020040);
        put_node(21'h020040, 0, 24'h020080);
        put_node(21'h020080, 3, 24'h020000);
        run_walk(24'h020000, "r7_cycle3", 1'b0);

        mem.delete();
        for (int k = 0; k < 9; k++)
            put_node(21'h030000 + 21'(k * 64), $urandom % 5,
                     (k == 8) ? 24'h0300C0 : ptr(21'h030000 + 21'((k + 1) * 64)));
        run_walk(24'h030000, "r7_tail_cycle", 1'b0);

        // R8: long chain with a true terminator; its stop bit must survive cleanup.
        mem.delete();
        for (int k = 0; k < 14; k++)
            put_node(21'h1F0000 + 21'(k * 64), $urandom % 4,
                     (k == 13) ? 24'hC0_0123 : 24'h1F0000 + 24'((k + 1) * 64));
        run_walk(24'h1F0000, "r8_long_term", 1'b1);
        chk(got_addr == 24'hC0_0123, "R8", "terminator kept", got_addr, 24'hC0_0123);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule